// File: doc/BRIEF.md
# Half-Rate Clocked Serial Control Transmitter

This block sends one fixed-length control word to a mixed-signal device over a three-wire port. The wires are a free-running system clock, an active-low enable and a single data line. The receiver makes its own half-rate clock, and that clock starts to toggle only once the enable is low. The transmitter therefore counts clock edges in step with that hidden half-rate clock. This lets it place every data bit around the receiver's sampling instant. It also releases the enable at the one point where the receiver will not begin a second transfer.

All of the block's registers switch on the falling edge of the system clock. The enable therefore drops half a clock period before the rising edge at which the receiver notices it. That lead falls inside the receiver's permitted setup window. The receiver's half-rate clock rises on each odd-numbered falling edge after the assertion edge (edge 0). The transmitter changes its data on the even-numbered edges in between. A controller outside this block issues a one-cycle start request with the word. It then waits for the busy flag to drop before it sends the next word.

Top module: `tsp_halfrate_tx`

## Requirements
- R1: While reset is held and after reset, ten_n is 1, tdat is 0 and busy is 0.
- R2: A start seen at a falling clock edge while idle drives ten_n low at that same edge (edge 0), half a period before the next rising edge.
- R3: Once asserted, ten_n stays low for exactly 2*NBITS clock periods (14 with the default width), from edge 0 up to edge 2*NBITS.
- R4: The word goes out most significant bit first. Bit position NBITS-1-j is driven on tdat from falling edge 2j to falling edge 2j+2, so it is stable across the receiver's sampling edge 2j+1.
- R5: tdat is 0 whenever ten_n is high.
- R6: ten_n returns high at falling edge 2*NBITS, one full period after the last sample at edge 2*NBITS-1 and before the following rising edge.
- R7: busy is 1 exactly while ten_n is low.
- R8: A start request made while busy is ignored, including one made at the release edge; the transfer in progress and its data continue unchanged.
- R9: A start held at the falling edge after the release begins a new transfer at once, so ten_n is high for exactly one clock period between two back-to-back transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock also seen by the receiver; the block uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, sampled on the falling clock edge |
| word | input | NBITS | Control word to send, captured with the start request |
| ten_n | output | 1 | Active-low transfer enable to the receiver |
| tdat | output | 1 | Serial data to the receiver |
| busy | output | 1 | High while a transfer occupies the port |

## Verification
On every falling edge the assertions check four things: that an idle start opens a transfer with the step counter at zero, that the enable stays low until the final step and then rises, that data holds still over each receiver sampling edge, and that the data line is quiet while the enable is high. The exact MSB-first bit values, the total enable width and the ignoring of start requests at the release edge are checked only by the bench. It compares every cycle against a queue-based reference, across several words, held and mid-transfer start requests, back-to-back transfers and a reset during a transfer.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
    // Steps in one transfer: two clock periods per bit.
    function automatic int step_count(input int nbits);
        return 2 * nbits;
    endfunction

    // Counter width able to hold steps 0 .. step_count-1.
    function automatic int step_width(input int nbits);
        return $clog2(2 * nbits);
    endfunction
endpackage

// File: rtl/tsp_seq.sv
`timescale 1ns/1ps
module tsp_seq
    import tsp_pkg::*;
#(
    parameter int NBITS = 7,
    localparam int LAST = step_count(NBITS) - 1,
    localparam int CW = step_width(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          active,
    output logic [CW-1:0] step,
    output logic          load,
    output logic          shift,
    output logic          release_now
);
    localparam logic [CW-1:0] LASTC = CW'(LAST);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d     = q;
        load  = 1'b0;
        shift = 1'b0;
        if (!q.act) begin
            if (start) begin
                d.act = 1'b1;
                d.cnt = '0;
                load  = 1'b1;
            end
        end else if (q.cnt == LASTC) begin
            d.act = 1'b0;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
            shift = q.cnt[0];
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active      = q.act;
    assign step        = q.cnt;
    assign release_now = q.act && (q.cnt == LASTC);

    assert_open_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (!q.act && start) |=> (q.act && q.cnt == '0));

    assert_hold_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (q.act && q.cnt != LASTC) |=> q.act);

    assert_release_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (q.act && q.cnt == LASTC) |=> !q.act);

    // R8: a start while busy never restarts the step count
    assert_ignore_R8: assert property (@(negedge clk) disable iff (!rst_n)
        (q.act && start && q.cnt != LASTC) |=> (q.cnt != '0));
endmodule

// File: rtl/tsp_shift.sv
`timescale 1ns/1ps
module tsp_shift #(
    parameter int NBITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             clear,
    input  logic [NBITS-1:0] word,
    output logic             bit_out
);
    typedef struct packed {
        logic [NBITS-1:0] sh;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.sh = word;
        end else if (shift) begin
            d.sh = {q.sh[NBITS-2:0], 1'b0};
        end else if (clear) begin
            d.sh = '0;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bit_out = q.sh[NBITS-1];
endmodule

// File: rtl/tsp_halfrate_tx.sv
`timescale 1ns/1ps
module tsp_halfrate_tx
    import tsp_pkg::*;
#(
    parameter int NBITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] word,
    output logic             ten_n,
    output logic             tdat,
    output logic             busy
);
    localparam int CW = step_width(NBITS);

    logic          active;
    logic [CW-1:0] step;
    logic          load;
    logic          shift;
    logic          release_now;

    tsp_seq #(.NBITS(NBITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .active      (active),
        .step        (step),
        .load        (load),
        .shift       (shift),
        .release_now (release_now)
    );

    tsp_shift #(.NBITS(NBITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .clear   (release_now),
        .word    (word),
        .bit_out (tdat)
    );

    assign ten_n = ~active;
    assign busy  = active;

    assert_quiet_R5: assert property (@(negedge clk) disable iff (!rst_n)
        ten_n |-> !tdat);

    // R4: on even steps the next edge is a receiver sampling edge
    assert_stable_R4: assert property (@(negedge clk) disable iff (!rst_n)
        (busy && !step[0]) |=> $stable(tdat));
endmodule

// File: tb/sim_tsp_halfrate_tx.sv
`timescale 1ns/1ps
module sim_tsp_halfrate_tx;
    localparam int NB = 7;
    localparam int STEPS = 2 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] word = '0;
    logic          ten_n, tdat, busy;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tsp_halfrate_tx #(.NBITS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word(word),
        .ten_n(ten_n), .tdat(tdat), .busy(busy)
    );

    // Reference: per-edge expected {ten_n, tdat, busy} and step index.
    int          exq[$];
    logic [2:0]  exp_v = 3'b100;
    int          exp_k = -1;
    int          prev_k = -1;
    bit          ign = 0;
    bit          back = 0;
    bit          valid = 0;

    always @(negedge clk) begin
        valid <= 1;
        if (!rst_n) begin
            exq.delete();
            exp_v = 3'b100;
            prev_k = -1;
            exp_k = -1;
            ign = 0;
            back = 0;
        end else begin
            ign = 0;
            if (exq.size() == 0 && start) begin
                for (int k = 0; k < STEPS; k++)
                    exq.push_back(k * 8 + {1'b0, word[NB-1-k/2], 1'b1});
                exq.push_back(STEPS * 8 + 3'b100);
            end else if (exq.size() != 0 && start) begin
                ign = 1;
            end
            prev_k = exp_k;
            if (exq.size() != 0) begin
                int v;
                v = exq.pop_front();
                exp_v = v[2:0];
                exp_k = v / 8;
            end else begin
                exp_v = 3'b100;
                exp_k = STEPS + 1;
            end
            back = (exp_k == 0 && prev_k == STEPS);
        end
    end

    function automatic string tag_of(int k, bit ig, bit bk, logic [2:0] got, logic [2:0] ex);
        if (k < 0)           return "R1";
        if (bk)              return "R9";
        if (ig)              return "R8";
        if (k == 0)          return "R2";
        if (k == STEPS)      return "R6";
        if (got[0] !== ex[0]) return "R7";
        if (got[1] !== ex[1]) return (k > STEPS) ? "R5" : "R4";
        return "R3";
    endfunction

    always @(posedge clk) begin
        if (valid && !done) begin
            logic [2:0] got;
            got = {ten_n, tdat, busy};
            n_cmp++;
            if (got !== exp_v) begin
                n_bad++;
                $display("FAIL %s step=%0d: actual ten_n=%0b tdat=%0b busy=%0b expected ten_n=%0b tdat=%0b busy=%0b",
                         tag_of(exp_k, ign, back, got, exp_v), exp_k,
                         got[2], got[1], got[0], exp_v[2], exp_v[1], exp_v[0]);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send(logic [NB-1:0] w);
        @(posedge clk); #1; start = 1; word = w;
        @(posedge clk); #1; start = 0;
        idle(STEPS + 2);
    endtask

    initial begin
        idle(3);                      // R1: reset state compared each cycle
        #1 rst_n = 1;
        idle(2);
        send(7'h55);                  // R2 R3 R4 R6 R7
        send(7'h2A);
        send(7'h7F);
        send(7'h00);                  // R5 R4: all-zero word
        send(7'h41);
        // R8: start pulse with a different word in mid transfer
        @(posedge clk); #1; start = 1; word = 7'h33;
        @(posedge clk); #1; start = 0;
        idle(5);
        #0; start = 1; word = 7'h4C;
        @(posedge clk); #1; start = 0;
        idle(STEPS + 2);
        // R8 R9: start held high across release edges, word changing
        @(posedge clk); #1; start = 1; word = 7'h19;
        for (int i = 0; i < 3 * (STEPS + 1); i++) begin
            @(posedge clk); #1; word = word + 7'h0B;
        end
        start = 0;
        idle(STEPS + 2);
        // R1: reset during a transfer
        @(posedge clk); #1; start = 1; word = 7'h66;
        @(posedge clk); #1; start = 0;
        idle(6);
        #0; rst_n = 0;
        idle(3);
        #1 rst_n = 1;
        send(7'h5A);
        idle(4);
        finish_run();
    end
endmodule